// File: doc/BRIEF.md
# Serial Controller Host Register Bank

This block is the processor-facing register file of a programmable serial controller. A host reaches it through a 3-bit address, a chip select, separate read and write strobes and an 8-bit data bus. It holds the line-control, interrupt-enable, modem-control and scratch bytes and a 16-bit baud divisor. It drives their fields straight to the serial engines. Status produced elsewhere (interrupt identification, line status, modem status and the received byte) comes in as plain inputs and is only read back.

The top bit of the line-control byte is a bank switch. While it is clear, address 0 is the data port: a write loads the transmit holding byte and a read returns the received byte. Address 1 is then the interrupt-enable byte. While it is set, addresses 0 and 1 reach the low and high divisor bytes. Addresses 2 to 7 decode the same way in both banks.

A host write to the transmit holding byte produces a one-cycle load strobe. A host read of the receive byte produces a one-cycle take strobe. The engines use these to update their flags. The data movement uses these plain strobes and has no valid/ready handshake: the engines must accept a load in any cycle, so there is no back-pressure toward the host.

Top module: `uart_hostregs`

## Requirements
- R1: After reset the line-control, interrupt-enable, modem-control and scratch bytes and the divisor are all zero, and both strobes are low.
- R2: With the bank bit clear, a write to address 0 raises `tx_load` for exactly the cycle after the write edge, with `tx_byte` holding the written byte. A read of address 0 returns `rx_byte` on `rdata` and raises `rx_take` for the cycle after the read edge.
- R3: With the bank bit clear, address 1 reads and writes the interrupt-enable byte, which drives `int_en`.
- R4: With the bank bit set, address 0 reads and writes divisor bits 7:0 and address 1 reads and writes divisor bits 15:8. In this bank, neither strobe fires and the interrupt-enable byte is not changed.
- R5: In either bank, address 2 reads `int_id`, address 3 the line-control byte, address 4 the modem-control byte, address 5 `line_stat`, address 6 `modem_stat` and address 7 the scratch byte.
- R6: The line-control byte has these fields: bits 1:0 word length (00=5, 01=6, 10=7, 11=8 bits) on `word_len`, bit 2 `stop_sel`, bit 3 `par_en`, bit 4 `par_even`, bit 5 `par_stick`, bit 6 `brk_force`, and bit 7 the bank bit.
- R7: The scratch byte reads back what was written, and writing it changes no output other than its own readback.
- R8: Writes to addresses 2, 5 and 6 are ignored. No stored byte, divisor bit or strobe changes.
- R9: Without chip select, a strobe has no effect. `rdata` is zero whenever a selected read is not in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| rx_byte | input | 8 | Received byte from the receive engine |
| int_id | input | 8 | Interrupt identification value |
| line_stat | input | 8 | Line status value |
| modem_stat | input | 8 | Modem status value |
| word_len | output | 2 | Word length code |
| stop_sel | output | 1 | Extra stop bit select |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity select |
| par_stick | output | 1 | Stick parity |
| brk_force | output | 1 | Force break on the line |
| divisor | output | 16 | Baud divisor |
| int_en | output | 8 | Interrupt enable byte |
| modem_ctl | output | 8 | Modem control byte |
| tx_load | output | 1 | One-cycle transmit holding load strobe |
| tx_byte | output | 8 | Byte to transmit, valid with `tx_load` |
| rx_take | output | 1 | One-cycle receive buffer read strobe |

## Verification
The strobe assertions assume that a host access lasts one clock and that `rd` and `wr` are never high together. Under those conditions each strobe can be traced to exactly one access in the cycle before it. The bench tasks drive every access for a single cycle between falling edges and return all controls low afterwards. They never raise read and write together, so the stimulus stays inside these assumptions. The divisor and line-control hold assertions rely only on the write strobe and address, which the bench always drives to known values.

// File: rtl/uart_hr_pkg.sv
package uart_hr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    SEL_DATA, SEL_IER, SEL_DLL, SEL_DLM, SEL_IIR,
    SEL_LCR, SEL_MCR, SEL_LSR, SEL_MSR, SEL_SCR
  } sel_e;

  localparam int NSEL = 10;

  typedef struct packed {
    logic       bank;
    logic       brk;
    logic       stick;
    logic       even;
    logic       par_en;
    logic       stop;
    logic [1:0] wlen;
  } linectl_t;
endpackage

// File: rtl/uart_hr_decode.sv
module uart_hr_decode
  import uart_hr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bank,
  output logic [NSEL-1:0]   sel
);
  always_comb begin
    sel = '0;
    case (addr)
      3'd0: if (bank) sel[SEL_DLL] = 1'b1; else sel[SEL_DATA] = 1'b1;
      3'd1: if (bank) sel[SEL_DLM] = 1'b1; else sel[SEL_IER] = 1'b1;
      3'd2: sel[SEL_IIR] = 1'b1;
      3'd3: sel[SEL_LCR] = 1'b1;
      3'd4: sel[SEL_MCR] = 1'b1;
      3'd5: sel[SEL_LSR] = 1'b1;
      3'd6: sel[SEL_MSR] = 1'b1;
      default: sel[SEL_SCR] = 1'b1;
    endcase
  end

  // R5: exactly one register is selected for any address
  always_comb begin
    a_r5_one_select: assert ($countones(sel) == 1);
  end
endmodule

// File: rtl/uart_hr_divisor.sv
module uart_hr_divisor #(
  parameter int DIV_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIV_W/BYTE_W-1:0] we_byte,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [DIV_W-1:0]        divisor
);
  localparam int NB = DIV_W / BYTE_W;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          divisor[b*BYTE_W +: BYTE_W] <= '0;
      else if (we_byte[b]) divisor[b*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  // R4: divisor changes only through a byte write enable
  a_r4_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (we_byte == '0) |=> $stable(divisor));
endmodule

// File: rtl/uart_hr_ctlregs.sv
module uart_hr_ctlregs
  import uart_hr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_ier,
  input  logic              we_lcr,
  input  logic              we_mcr,
  input  logic              we_scr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ier_q,
  output linectl_t          lcr_q,
  output logic [DATA_W-1:0] mcr_q,
  output logic [DATA_W-1:0] scr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      scr_q <= '0;
    end else begin
      if (we_ier) ier_q <= wdata;
      if (we_lcr) lcr_q <= linectl_t'(wdata);
      if (we_mcr) mcr_q <= wdata;
      if (we_scr) scr_q <= wdata;
    end
  end

  // R8: line-control byte holds unless it is written
  a_r8_lcr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_lcr |=> $stable(lcr_q));
  // R3: interrupt-enable byte holds unless it is written
  a_r3_ier_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we_ier |=> $stable(ier_q));
endmodule

// File: rtl/uart_hostregs.sv
module uart_hostregs
  import uart_hr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] int_id,
  input  logic [DATA_W-1:0] line_stat,
  input  logic [DATA_W-1:0] modem_stat,
  output logic [1:0]        word_len,
  output logic              stop_sel,
  output logic              par_en,
  output logic              par_even,
  output logic              par_stick,
  output logic              brk_force,
  output logic [DIV_W-1:0]  divisor,
  output logic [DATA_W-1:0] int_en,
  output logic [DATA_W-1:0] modem_ctl,
  output logic              tx_load,
  output logic [DATA_W-1:0] tx_byte,
  output logic              rx_take
);
  localparam int NB = DIV_W / DATA_W;

  logic [NSEL-1:0]   sel;
  logic              wr_fire, rd_fire;
  linectl_t          lcr_q;
  logic [DATA_W-1:0] scr_q;
  logic [NB-1:0]     div_we;

  assign wr_fire = cs && wr;
  assign rd_fire = cs && rd;

  uart_hr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .bank (lcr_q.bank),
    .sel  (sel)
  );

  uart_hr_ctlregs #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_ier (wr_fire && sel[SEL_IER]),
    .we_lcr (wr_fire && sel[SEL_LCR]),
    .we_mcr (wr_fire && sel[SEL_MCR]),
    .we_scr (wr_fire && sel[SEL_SCR]),
    .wdata  (wdata),
    .ier_q  (int_en),
    .lcr_q  (lcr_q),
    .mcr_q  (modem_ctl),
    .scr_q  (scr_q)
  );

  assign div_we = {wr_fire && sel[SEL_DLM], wr_fire && sel[SEL_DLL]};

  uart_hr_divisor #(.DIV_W(DIV_W), .BYTE_W(DATA_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_byte (div_we),
    .wdata   (wdata),
    .divisor (divisor)
  );

  assign word_len  = lcr_q.wlen;
  assign stop_sel  = lcr_q.stop;
  assign par_en    = lcr_q.par_en;
  assign par_even  = lcr_q.even;
  assign par_stick = lcr_q.stick;
  assign brk_force = lcr_q.brk;

  // Read data path
  always_comb begin
    rdata = '0;
    if (rd_fire) begin
      unique case (1'b1)
        sel[SEL_DATA]: rdata = rx_byte;
        sel[SEL_IER]:  rdata = int_en;
        sel[SEL_DLL]:  rdata = divisor[DATA_W-1:0];
        sel[SEL_DLM]:  rdata = divisor[DIV_W-1 -: DATA_W];
        sel[SEL_IIR]:  rdata = int_id;
        sel[SEL_LCR]:  rdata = lcr_q;
        sel[SEL_MCR]:  rdata = modem_ctl;
        sel[SEL_LSR]:  rdata = line_stat;
        sel[SEL_MSR]:  rdata = modem_stat;
        default:       rdata = scr_q;
      endcase
    end
  end

  // Engine strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_load <= 1'b0;
      rx_take <= 1'b0;
      tx_byte <= '0;
    end else begin
      tx_load <= wr_fire && sel[SEL_DATA];
      rx_take <= rd_fire && sel[SEL_DATA];
      if (wr_fire && sel[SEL_DATA]) tx_byte <= wdata;
    end
  end

  // R2: a load strobe follows a bank-0 write to address 0
  a_r2_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_load) |-> $past(cs && wr && addr == '0));
  // R2: a take strobe follows a bank-0 read of address 0
  a_r2_rx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_take) |-> $past(cs && rd && addr == '0));
  // R4: no strobe while the divisor bank is mapped
  a_r4_bank_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (lcr_q.bank && addr == '0) |=> !tx_load && !rx_take);
  // R9: no read data without a selected read
  a_r9_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> rdata == '0);
endmodule

// File: tb/uart_hostregs_tb.sv
module uart_hostregs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 0, rd = 0, wr = 0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] rx_byte = 8'hC3, int_id = 8'h01, line_stat = 8'h60, modem_stat = 8'hB0;
  logic [1:0] word_len;
  logic       stop_sel, par_en, par_even, par_stick, brk_force;
  logic [15:0] divisor;
  logic [7:0] int_en, modem_ctl, tx_byte;
  logic       tx_load, rx_take;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_hostregs dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_byte(rx_byte), .int_id(int_id),
    .line_stat(line_stat), .modem_stat(modem_stat), .word_len(word_len),
    .stop_sel(stop_sel), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .brk_force(brk_force), .divisor(divisor),
    .int_en(int_en), .modem_ctl(modem_ctl), .tx_load(tx_load),
    .tx_byte(tx_byte), .rx_take(rx_take)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One-cycle write; returns at the falling edge after the write edge
  task automatic host_wr(input logic [2:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  // One-cycle read; data sampled before the edge
  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic t_reset;
    chk("R1", "lcr fields", {8'h0, 1'b0, brk_force, par_stick, par_even, par_en, stop_sel, word_len}, 16'h0);
    chk("R1", "divisor", divisor, 16'h0);
    chk("R1", "int_en", {8'h0, int_en}, 16'h0);
    chk("R1", "modem_ctl", {8'h0, modem_ctl}, 16'h0);
    chk("R1", "strobes", {14'h0, tx_load, rx_take}, 16'h0);
    chk("R9", "idle rdata", {8'h0, rdata}, 16'h0);
  endtask

  task automatic t_data_port;
    logic [7:0] d;
    host_wr(3'd0, 8'h5A);
    chk("R2", "tx_load pulse", {15'h0, tx_load}, 16'h1);
    chk("R2", "tx_byte", {8'h0, tx_byte}, 16'h5A);
    @(negedge clk);
    chk("R2", "tx_load one cycle", {15'h0, tx_load}, 16'h0);
    host_rd(3'd0, d);
    chk("R2", "rx read", {8'h0, d}, 16'hC3);
    chk("R2", "rx_take pulse", {15'h0, rx_take}, 16'h1);
    chk("R2", "no tx on read", {15'h0, tx_load}, 16'h0);
    @(negedge clk);
    chk("R2", "rx_take one cycle", {15'h0, rx_take}, 16'h0);
  endtask

  task automatic t_ier;
    logic [7:0] d;
    host_wr(3'd1, 8'h0B);
    chk("R3", "int_en", {8'h0, int_en}, 16'h0B);
    host_rd(3'd1, d);
    chk("R3", "ier readback", {8'h0, d}, 16'h0B);
  endtask

  task automatic t_lcr_fields;
    logic [7:0] d;
    host_wr(3'd3, 8'h3A);
    chk("R6", "fields 3A", {9'h0, brk_force, par_stick, par_even, par_en, stop_sel, word_len}, 16'h003A);
    chk("R6", "word_len 7 bits", {14'h0, word_len}, 16'h2);
    host_wr(3'd3, 8'h45);
    chk("R6", "fields 45", {9'h0, brk_force, par_stick, par_even, par_en, stop_sel, word_len}, 16'h0045);
    chk("R6", "break", {15'h0, brk_force}, 16'h1);
    host_rd(3'd3, d);
    chk("R5", "lcr readback", {8'h0, d}, 16'h45);
  endtask

  task automatic t_divisor_bank;
    logic [7:0] d;
    host_wr(3'd3, 8'h83);
    host_wr(3'd0, 8'h34);
    chk("R4", "no tx_load in bank 1", {15'h0, tx_load}, 16'h0);
    host_wr(3'd1, 8'h12);
    chk("R4", "divisor", divisor, 16'h1234);
    chk("R4", "int_en untouched", {8'h0, int_en}, 16'h0B);
    host_rd(3'd0, d);
    chk("R4", "dll readback", {8'h0, d}, 16'h34);
    chk("R4", "no rx_take in bank 1", {15'h0, rx_take}, 16'h0);
    host_rd(3'd1, d);
    chk("R4", "dlm readback", {8'h0, d}, 16'h12);
    host_rd(3'd2, d);
    chk("R5", "iir bank 1", {8'h0, d}, 16'h01);
    host_rd(3'd5, d);
    chk("R5", "lsr bank 1", {8'h0, d}, 16'h60);
    host_rd(3'd6, d);
    chk("R5", "msr bank 1", {8'h0, d}, 16'hB0);
    host_wr(3'd7, 8'hE7);
    host_rd(3'd7, d);
    chk("R5", "scratch bank 1", {8'h0, d}, 16'hE7);
    host_wr(3'd3, 8'h03);
    host_rd(3'd1, d);
    chk("R4", "ier back after bank 0", {8'h0, d}, 16'h0B);
    chk("R4", "divisor kept", divisor, 16'h1234);
  endtask

  task automatic t_mcr_scratch;
    logic [7:0] d;
    host_wr(3'd4, 8'h1F);
    chk("R5", "modem_ctl", {8'h0, modem_ctl}, 16'h1F);
    host_rd(3'd4, d);
    chk("R5", "mcr readback", {8'h0, d}, 16'h1F);
    host_wr(3'd7, 8'hA5);
    host_rd(3'd7, d);
    chk("R7", "scratch readback", {8'h0, d}, 16'hA5);
    chk("R7", "outputs unchanged", {int_en, modem_ctl}, 16'h0B1F);
    chk("R7", "lcr unchanged", {9'h0, brk_force, par_stick, par_even, par_en, stop_sel, word_len}, 16'h0003);
    chk("R7", "divisor unchanged", divisor, 16'h1234);
  endtask

  task automatic t_readonly_writes;
    logic [7:0] d;
    foreach (d[i]) d[i] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      logic [2:0] a;
      a = (k == 0) ? 3'd2 : (k == 1) ? 3'd5 : 3'd6;
      host_wr(a, 8'hFF);
      chk("R8", "no tx strobe", {15'h0, tx_load}, 16'h0);
    end
    chk("R8", "regs kept", {int_en, modem_ctl}, 16'h0B1F);
    chk("R8", "lcr kept", {9'h0, brk_force, par_stick, par_even, par_en, stop_sel, word_len}, 16'h0003);
    chk("R8", "divisor kept", divisor, 16'h1234);
    host_rd(3'd7, d);
    chk("R8", "scratch kept", {8'h0, d}, 16'hA5);
    host_rd(3'd2, d);
    chk("R8", "iir still input", {8'h0, d}, 16'h01);
  endtask

  task automatic t_no_select;
    host_wr(3'd0, 8'h77, 1'b0);
    chk("R9", "no tx_load without cs", {15'h0, tx_load}, 16'h0);
    host_wr(3'd4, 8'h00, 1'b0);
    chk("R9", "mcr kept without cs", {8'h0, modem_ctl}, 16'h1F);
    @(negedge clk);
    rd = 1; addr = 3'd0;
    #1 chk("R9", "rdata without cs", {8'h0, rdata}, 16'h0);
    @(negedge clk);
    chk("R9", "no rx_take without cs", {15'h0, rx_take}, 16'h0);
    rd = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_data_port();
    t_ier();
    t_lcr_fields();
    t_divisor_bank();
    t_mcr_scratch();
    t_readonly_writes();
    t_no_select();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule